// File: doc/BRIEF.md
# SD Command and Response Engine

This block issues a single SD/MMC command on the CMD line and collects the card's reply. Software fills in a 32-bit argument, a configuration word and a send word through a small register port. The send word carries the command index, the response length and option flags. Writing the send word starts the command. The engine shifts out the 48-bit command frame with its CRC7 and then releases the line. It waits for the card's start bit and clocks in the programmed number of response bits, checking CRC7 as they arrive. If asked, it then waits for the card to release DAT0 from busy.

At the end of a command the engine sets a command-done status flag, which can also raise an interrupt. Software reads the captured response back one 32-bit word at a time through the argument address, using a read-out mode and an auto-incrementing word index. The card clock itself is generated elsewhere. The engine receives two single-cycle strobes, one for each card-clock edge, and acts only on them.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, cmd_oe is 0, cmd_out is 1 and irq is 0. Status (address 3) reads 0, and configuration (address 2) reads 0x0002_7800, which means a frame-bit field of 39 with drive on the rising strobe.
- R2: A command frame holds the bits {0, 1, index[5:0], argument[31:0]} MSB first, limited to configuration[17:12]+1 bits. Then come the CRC7 (polynomial x^7+x^3+1, zero seed) over those bits, an end bit of 1, and release of cmd_oe. If configuration bit 10 is set, the CRC7 is left out.
- R3: cmd_out changes only on card_rise when configuration bit 11 is 1, and only on card_fall when it is 0. cmd_in and dat0_in are sampled on card_fall when configuration bit 18 is 1, and on card_rise when it is 0.
- R4: When send[15:8]=N with N>0, the engine waits for a 0 start bit on cmd_in. It then captures N+1 bits and the end bit. When N=0, no response is expected.
- R5: Status bit 5 (CRC OK) is set at completion if the CRC7 remainder over the N+1 bits after the start bit is zero. When send bit 18 is set, the first 7 of those bits are left out of the check. When send bit 16 is set, the check is skipped and the flag reads 1.
- R6: Read-out control (address 5) holds a mode flag in bit 8 and a word index in bits 15:12. With the mode flag set, a read of address 0 returns response word k, which is bits [32k+39 : 32k+8] of the bits captured after the start bit (the end bit lands at bit 0). Each such read advances k by one.
- R7: With send bit 19 set, completion waits until dat0_in is sampled high after the response. Until then, status bit 4 (busy) stays 1 and bit 9 stays 0.
- R8: If no start bit arrives within RSP_TIMEOUT sampling strobes, status bit 16 (timeout) and bit 9 are set, and bit 5 is clear.
- R9: Status bit 9 (done) is set at completion. Writing 1 to bit 5, 9 or 16 of address 3 clears that bit.
- R10: irq equals status bit 9 AND bit 4 of interrupt control (address 4).
- R11: A write to the send word (address 1) while a command is in flight is ignored. The register keeps its old value and no frame is sent.
- R12: Writing bit 15 of address 4 aborts the command. It clears the status bits and releases cmd_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle |
| card_rise | input | 1 | Strobe marking a rising card-clock edge |
| card_fall | input | 1 | Strobe marking a falling card-clock edge |
| cmd_in | input | 1 | CMD line as seen from the card |
| cmd_out | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| dat0_in | input | 1 | DAT0 line, low while the card is busy |
| irq | output | 1 | Command-done interrupt |

## Verification
The bench builds the engine with RSP_TIMEOUT=16 and the default RSP_WORDS=4. The short timeout makes the no-response path finish in a few dozen card periods. Four words are enough to read back a full 136-bit long response word by word. A scoreboard compares every frame the engine drives with the bit sequence computed for it. This covers frames with and without CRC, and both edge selections. The bench runs short, long, skipped-check and deliberately corrupted responses, and shows that a blocked send write leaves no extra frame behind.

// File: rtl/sdce_pkg.sv
package sdce_pkg;

    localparam logic [2:0] A_ARG   = 3'd0;
    localparam logic [2:0] A_SEND  = 3'd1;
    localparam logic [2:0] A_CONF  = 3'd2;
    localparam logic [2:0] A_STAT  = 3'd3;
    localparam logic [2:0] A_IRQC  = 3'd4;
    localparam logic [2:0] A_RDCTL = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE, S_TXF, S_TXC, S_TXE, S_TXR, S_RXW, S_RX, S_BSY, S_DONE
    } eng_state_e;

    typedef struct packed {
        logic [5:0]  idx;
        logic [7:0]  rsp_len;
        logic        chk_off;
        logic        crc_from8;
        logic        wait_busy;
        logic [31:0] arg;
        logic [5:0]  frame_bits;
        logic        txcrc_off;
        logic        drive_pos;
        logic        latch_neg;
    } cmd_cfg_t;

    // one serial step of CRC7, generator x^7 + x^3 + 1
    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:3], c[2] ^ fb, c[1:0], fb};
    endfunction

endpackage

// File: rtl/sdce_regs.sv
module sdce_regs
    import sdce_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic        rd,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        eng_busy,
    input  logic        eng_done,
    input  logic        eng_ok,
    input  logic        eng_to,
    input  logic [31:0] rsp_word,
    output logic        start,
    output logic        soft_rst,
    output cmd_cfg_t    cfg,
    output logic [3:0]  rd_idx,
    output logic        irq
);

    typedef struct packed {
        logic [31:0] arg;
        logic [31:0] send;
        logic [31:0] conf;
        logic        irq_en;
        logic        rd_mode;
        logic [3:0]  rd_idx;
        logic        st_done;
        logic        st_ok;
        logic        st_to;
        logic        start;
        logic        srst;
    } reg_t;

    localparam reg_t REG_RST = '{arg: '0, send: '0, conf: 32'h0002_7800,
                                 irq_en: 1'b0, rd_mode: 1'b0, rd_idx: '0,
                                 st_done: 1'b0, st_ok: 1'b0, st_to: 1'b0,
                                 start: 1'b0, srst: 1'b0};

    reg_t d, q;
    logic cmd_busy;
    logic srst_wr;

    assign cmd_busy = eng_busy | q.start;
    assign srst_wr  = wr && (addr == A_IRQC) && wdata[15];

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.srst  = 1'b0;
        rdata   = '0;
        if (wr) begin
            unique case (addr)
                A_ARG:  d.arg = wdata;
                A_SEND: if (!cmd_busy) begin
                    d.send  = wdata;
                    d.start = 1'b1;
                end
                A_CONF: d.conf = wdata;
                A_STAT: begin
                    if (wdata[9])  d.st_done = 1'b0;
                    if (wdata[5])  d.st_ok   = 1'b0;
                    if (wdata[16]) d.st_to   = 1'b0;
                end
                A_IRQC: begin
                    d.irq_en = wdata[4];
                    if (wdata[15]) begin
                        d.srst    = 1'b1;
                        d.st_done = 1'b0;
                        d.st_ok   = 1'b0;
                        d.st_to   = 1'b0;
                        d.rd_idx  = '0;
                    end
                end
                A_RDCTL: begin
                    d.rd_mode = wdata[8];
                    d.rd_idx  = wdata[15:12];
                end
                default: ;
            endcase
        end
        if (eng_done && !srst_wr) begin
            d.st_done = 1'b1;
            d.st_ok   = eng_ok;
            d.st_to   = eng_to;
        end
        unique case (addr)
            A_ARG: begin
                rdata = q.rd_mode ? rsp_word : q.arg;
                if (rd && q.rd_mode) d.rd_idx = q.rd_idx + 4'd1;
            end
            A_SEND:  rdata = q.send;
            A_CONF:  rdata = q.conf;
            A_STAT:  rdata = {15'b0, q.st_to, 6'b0, q.st_done, 3'b0, q.st_ok, cmd_busy, 4'b0};
            A_IRQC:  rdata = {27'b0, q.irq_en, 4'b0};
            A_RDCTL: rdata = {16'b0, q.rd_idx, 3'b0, q.rd_mode, 8'b0};
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REG_RST;
        else        q <= d;
    end

    assign start    = q.start;
    assign soft_rst = q.srst;
    assign rd_idx   = q.rd_idx;
    assign irq      = q.st_done & q.irq_en;

    always_comb begin
        cfg.idx        = q.send[5:0];
        cfg.rsp_len    = q.send[15:8];
        cfg.chk_off    = q.send[16];
        cfg.crc_from8  = q.send[18];
        cfg.wait_busy  = q.send[19];
        cfg.arg        = q.arg;
        cfg.frame_bits = q.conf[17:12];
        cfg.txcrc_off  = q.conf[10];
        cfg.drive_pos  = q.conf[11];
        cfg.latch_neg  = q.conf[18];
    end

    // R11
    send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_SEND && cmd_busy) |=> $stable(q.send));

    // R9
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !srst_wr) |=> q.st_done);

    // R8
    to_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.st_to |-> !q.st_ok);

endmodule

// File: rtl/sdce_rspbuf.sv
module sdce_rspbuf #(
    parameter int WORDS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        shift_en,
    input  logic        bit_in,
    input  logic [3:0]  rd_idx,
    output logic [31:0] word
);

    localparam int SR_W = 32 * WORDS + 8;

    logic [SR_W-1:0] sr_d, sr_q;
    logic [31:0]     words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign words[g] = sr_q[32*g+8 +: 32];
    end

    always_comb begin
        sr_d = sr_q;
        if (clear)         sr_d = '0;
        else if (shift_en) sr_d = {sr_q[SR_W-2:0], bit_in};
        word = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (rd_idx == 4'(k)) word = words[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

endmodule

// File: rtl/sdce_engine.sv
module sdce_engine
    import sdce_pkg::*;
#(
    parameter int RSP_TIMEOUT = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     soft_rst,
    input  logic     start,
    input  cmd_cfg_t cfg,
    input  logic     card_rise,
    input  logic     card_fall,
    input  logic     cmd_in,
    input  logic     dat0_in,
    output logic     cmd_out,
    output logic     cmd_oe,
    output logic     busy,
    output logic     done,
    output logic     crc_ok,
    output logic     timed_out,
    output logic     rx_valid,
    output logic     rx_bit,
    output logic     rx_clear
);

    localparam int TW = $clog2(RSP_TIMEOUT + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(RSP_TIMEOUT - 1);

    typedef struct packed {
        eng_state_e  st;
        cmd_cfg_t    cfg;
        logic [39:0] txsr;
        logic [6:0]  crc;
        logic [8:0]  cnt;
        logic [TW-1:0] tmr;
        logic        oe;
        logic        out;
        logic        ok;
        logic        to;
    } eng_t;

    localparam eng_t ENG_RST = '{st: S_IDLE, cfg: '0, txsr: '0, crc: '0, cnt: '0,
                                 tmr: '0, oe: 1'b0, out: 1'b1, ok: 1'b0, to: 1'b0};

    eng_t d, q;
    logic drv, smp;
    logic [8:0] len9;

    assign drv  = q.cfg.drive_pos ? card_rise : card_fall;
    assign smp  = q.cfg.latch_neg ? card_fall : card_rise;
    assign len9 = {1'b0, q.cfg.rsp_len};

    always_comb begin
        d        = q;
        rx_valid = 1'b0;
        rx_bit   = cmd_in;
        rx_clear = 1'b0;
        unique case (q.st)
            S_IDLE: if (start) begin
                d.cfg  = cfg;
                d.txsr = {2'b01, cfg.idx, cfg.arg};
                d.crc  = '0;
                d.cnt  = '0;
                d.ok   = 1'b0;
                d.to   = 1'b0;
                d.st   = S_TXF;
                rx_clear = 1'b1;
            end
            S_TXF: if (drv) begin
                d.oe   = 1'b1;
                d.out  = q.txsr[39];
                d.txsr = {q.txsr[38:0], 1'b0};
                d.crc  = crc7_step(q.crc, q.txsr[39]);
                d.cnt  = q.cnt + 9'd1;
                if (q.cnt == {3'b0, q.cfg.frame_bits}) begin
                    d.cnt = '0;
                    d.st  = q.cfg.txcrc_off ? S_TXE : S_TXC;
                end
            end
            S_TXC: if (drv) begin
                d.out = q.crc[6];
                d.crc = {q.crc[5:0], 1'b0};
                d.cnt = q.cnt + 9'd1;
                if (q.cnt == 9'd6) d.st = S_TXE;
            end
            S_TXE: if (drv) begin
                d.out = 1'b1;
                d.st  = S_TXR;
            end
            S_TXR: if (drv) begin
                d.oe  = 1'b0;
                d.out = 1'b1;
                d.tmr = '0;
                if (q.cfg.rsp_len == 8'd0) d.st = q.cfg.wait_busy ? S_BSY : S_DONE;
                else                       d.st = S_RXW;
            end
            S_RXW: if (smp) begin
                if (!cmd_in) begin
                    d.st  = S_RX;
                    d.cnt = '0;
                    d.crc = '0;
                end else if (q.tmr == TMR_LAST) begin
                    d.to = 1'b1;
                    d.st = S_DONE;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            S_RX: if (smp) begin
                rx_valid = 1'b1;
                d.cnt    = q.cnt + 9'd1;
                if (q.cnt <= len9 && (!q.cfg.crc_from8 || q.cnt >= 9'd7))
                    d.crc = crc7_step(q.crc, cmd_in);
                if (q.cnt == len9 + 9'd1) begin
                    d.ok = q.cfg.chk_off | (q.crc == 7'd0);
                    d.st = q.cfg.wait_busy ? S_BSY : S_DONE;
                end
            end
            S_BSY: if (smp && dat0_in) d.st = S_DONE;
            S_DONE: d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
        if (soft_rst) d = ENG_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    assign cmd_out   = q.out;
    assign cmd_oe    = q.oe;
    assign busy      = (q.st != S_IDLE);
    assign done      = (q.st == S_DONE);
    assign crc_ok    = q.ok;
    assign timed_out = q.to;

    // R2
    end_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cmd_oe) && !$past(soft_rst)) |-> $past(cmd_out));

    // R3
    drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv && !soft_rst) |=> $stable(cmd_out));

    // R12
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !cmd_oe));

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sdce_pkg::*;
#(
    parameter int RSP_TIMEOUT = 64,
    parameter int RSP_WORDS   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        card_rise,
    input  logic        card_fall,
    input  logic        cmd_in,
    output logic        cmd_out,
    output logic        cmd_oe,
    input  logic        dat0_in,
    output logic        irq
);

    cmd_cfg_t    cfg;
    logic        start, soft_rst;
    logic        eng_busy, eng_done, eng_ok, eng_to;
    logic        rx_valid, rx_bit, rx_clear;
    logic [3:0]  rd_idx;
    logic [31:0] rsp_word;

    sdce_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .eng_busy (eng_busy),
        .eng_done (eng_done),
        .eng_ok   (eng_ok),
        .eng_to   (eng_to),
        .rsp_word (rsp_word),
        .start    (start),
        .soft_rst (soft_rst),
        .cfg      (cfg),
        .rd_idx   (rd_idx),
        .irq      (irq)
    );

    sdce_engine #(.RSP_TIMEOUT(RSP_TIMEOUT)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .start     (start),
        .cfg       (cfg),
        .card_rise (card_rise),
        .card_fall (card_fall),
        .cmd_in    (cmd_in),
        .dat0_in   (dat0_in),
        .cmd_out   (cmd_out),
        .cmd_oe    (cmd_oe),
        .busy      (eng_busy),
        .done      (eng_done),
        .crc_ok    (eng_ok),
        .timed_out (eng_to),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .rx_clear  (rx_clear)
    );

    sdce_rspbuf #(.WORDS(RSP_WORDS)) i_rspbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_clear),
        .shift_en (rx_valid),
        .bit_in   (rx_bit),
        .rd_idx   (rd_idx),
        .word     (rsp_word)
    );

endmodule

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        card_rise, card_fall;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe;
    logic        dat0_in = 1'b1;
    logic        irq;
    logic [1:0]  phase = '0;

    bit drive_pos_b = 1'b1;
    bit latch_neg_b = 1'b0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [47:0] exp_frame_q[$];
    int          exp_len_q[$];

    always #5 clk = ~clk;

    initial forever begin
        @(posedge clk);
        phase <= rst_n ? phase + 2'd1 : 2'd0;
    end
    assign card_rise = (phase == 2'd0);
    assign card_fall = (phase == 2'd2);

    sd_cmd_engine #(.RSP_TIMEOUT(16), .RSP_WORDS(4)) i_sd_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .card_rise(card_rise), .card_fall(card_fall), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .dat0_in(dat0_in), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [6:0] crc_of(input logic [127:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic m;
            m = c[6] ^ v[i];
            c = {c[5:0], 1'b0};
            if (m) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // driver side of the scoreboard: expected frame goes into the queue
    task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                         input logic [31:0] flags, input bit crc_on);
        logic [39:0] body;
        body = {2'b01, idx, arg};
        if (crc_on) begin
            exp_frame_q.push_back({body, crc_of({88'b0, body}, 40), 1'b1});
            exp_len_q.push_back(48);
        end else begin
            exp_frame_q.push_back({7'b0, body, 1'b1});
            exp_len_q.push_back(41);
        end
        wr(3'd0, arg);
        wr(3'd1, flags | {26'b0, idx});
    endtask

    // monitor side: rebuild each driven frame and compare with the queue
    initial begin
        logic [47:0] frame = '0;
        int n = 0;
        forever begin
            bit strobe;
            @(posedge clk);
            strobe = drive_pos_b ? card_rise : card_fall;
            @(negedge clk);
            if (strobe && rst_n) begin
                if (cmd_oe) begin
                    frame = {frame[46:0], cmd_out};
                    n++;
                end else if (n > 0) begin
                    if (exp_frame_q.size() == 0) begin
                        check("R11", "unexpected frame", {16'b0, frame}, 64'h0);
                    end else begin
                        logic [47:0] ef;
                        int el;
                        ef = exp_frame_q.pop_front();
                        el = exp_len_q.pop_front();
                        check("R2", "frame length", 64'(n), 64'(el));
                        check("R2", "frame bits", {16'b0, frame}, {16'b0, ef});
                    end
                    n = 0;
                    frame = '0;
                end
            end
        end
    end

    task automatic wait_change_point();
        bit hit;
        hit = 1'b0;
        while (!hit) begin
            @(posedge clk);
            hit = latch_neg_b ? card_rise : card_fall;
        end
        #1;
    endtask

    task automatic card_rsp(input logic [135:0] bits, input int n);
        wait (cmd_oe);
        wait (!cmd_oe);
        repeat (2) wait_change_point();
        for (int i = n - 1; i >= 0; i--) begin
            cmd_in = bits[i];
            wait_change_point();
        end
        cmd_in = 1'b1;
    endtask

    function automatic logic [135:0] short_rsp(input logic [5:0] idx,
                                               input logic [31:0] st, input bit bad);
        logic [39:0] b;
        logic [6:0]  c;
        b = {2'b00, idx, st};
        c = crc_of({88'b0, b}, 40) ^ {6'b0, bad};
        return {88'b0, b, c, 1'b1};
    endfunction

    function automatic logic [135:0] long_rsp(input logic [119:0] cid);
        return {2'b00, 6'h3f, cid, crc_of({8'b0, cid}, 120), 1'b1};
    endfunction

    task automatic wait_done(input string req);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 3000 && !s[9]; i++) rd(3'd3, s);
        check(req, "done reached", {63'b0, s[9]}, 64'd1);
    endtask

    task automatic clear_status();
        wr(3'd3, 32'h0001_0220);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [119:0] cid;
        cid = 120'h11_2233_4455_6677_8899_aabb_ccdd_eeff;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "cmd_oe", {63'b0, cmd_oe}, 64'd0);
        check("R1", "cmd_out", {63'b0, cmd_out}, 64'd1);
        check("R1", "irq", {63'b0, irq}, 64'd0);
        rd(3'd3, v); check("R1", "status", {32'b0, v}, 64'h0);
        rd(3'd2, v); check("R1", "config", {32'b0, v}, 64'h0002_7800);

        wr(3'd4, 32'h10);

        // short response, R4 capture, R5 CRC ok, R6 word 0, R10 irq
        issue(6'd17, 32'h1234_5678, 32'h0000_2d00, 1'b1);
        card_rsp(short_rsp(6'd17, 32'hcafe_0900, 1'b0), 48);
        wait_done("R4");
        rd(3'd3, v); check("R5", "status short ok", {32'b0, v}, 64'h220);
        @(negedge clk); check("R10", "irq set", {63'b0, irq}, 64'd1);
        wr(3'd5, 32'h100);
        rd(3'd0, v); check("R6", "short word0", {32'b0, v}, 64'hcafe_0900);
        wr(3'd5, 32'h0);
        rd(3'd0, v); check("R6", "arg readback", {32'b0, v}, 64'h1234_5678);

        // R9 write-one-to-clear
        clear_status();
        rd(3'd3, v); check("R9", "status cleared", {32'b0, v}, 64'h0);
        @(negedge clk); check("R10", "irq cleared", {63'b0, irq}, 64'd0);

        // R5 corrupted CRC
        issue(6'd13, 32'h0, 32'h0000_2d00, 1'b1);
        card_rsp(short_rsp(6'd13, 32'h0000_0f00, 1'b1), 48);
        wait_done("R5");
        rd(3'd3, v); check("R5", "bad crc", {32'b0, v}, 64'h200);
        clear_status();

        // R5 check skipped
        issue(6'd13, 32'h1, 32'h0001_2d00, 1'b1);
        card_rsp(short_rsp(6'd13, 32'h0000_0f00, 1'b1), 48);
        wait_done("R5");
        rd(3'd3, v); check("R5", "check skipped", {32'b0, v}, 64'h220);
        clear_status();

        // long response with check from the 8th bit, R6 four words
        issue(6'd2, 32'h0, 32'h0004_8500, 1'b1);
        card_rsp(long_rsp(cid), 136);
        wait_done("R4");
        rd(3'd3, v); check("R5", "long ok", {32'b0, v}, 64'h220);
        wr(3'd5, 32'h100);
        rd(3'd0, v); check("R6", "long word0", {32'b0, v}, {32'b0, cid[31:0]});
        rd(3'd0, v); check("R6", "long word1", {32'b0, v}, {32'b0, cid[63:32]});
        rd(3'd0, v); check("R6", "long word2", {32'b0, v}, {32'b0, cid[95:64]});
        rd(3'd0, v); check("R6", "long word3", {32'b0, v}, {32'b0, 2'b00, 6'h3f, cid[119:96]});
        wr(3'd5, 32'h0);
        clear_status();

        // R5 long response checked from the first bit fails
        issue(6'd2, 32'h0, 32'h0000_8500, 1'b1);
        card_rsp(long_rsp(cid), 136);
        wait_done("R5");
        rd(3'd3, v); check("R5", "long full-range", {32'b0, v}, 64'h200);
        clear_status();

        // R8 timeout
        issue(6'd8, 32'h0000_01aa, 32'h0000_2d00, 1'b1);
        wait_done("R8");
        rd(3'd3, v); check("R8", "timeout status", {32'b0, v}, 64'h1_0200);
        clear_status();

        // R4 no response expected
        issue(6'd0, 32'h0, 32'h0, 1'b1);
        wait_done("R4");
        rd(3'd3, v); check("R4", "no response", {32'b0, v}, 64'h200);
        clear_status();

        // R7 busy wait and R11 ignored send
        dat0_in = 1'b0;
        issue(6'd12, 32'h0, 32'h0008_2d00, 1'b1);
        card_rsp(short_rsp(6'd12, 32'h0000_0700, 1'b0), 48);
        repeat (40) @(posedge clk);
        rd(3'd3, v); check("R7", "held busy", {32'b0, v}, 64'h10);
        wr(3'd1, 32'h0000_0005);
        repeat (20) @(posedge clk);
        dat0_in = 1'b1;
        wait_done("R7");
        rd(3'd3, v); check("R7", "after release", {32'b0, v}, 64'h220);
        rd(3'd1, v); check("R11", "send kept", {32'b0, v}, 64'h0008_2d0c);
        clear_status();

        // R2 frame without CRC
        wr(3'd2, 32'h0002_7c00);
        issue(6'd55, 32'hdead_beef, 32'h0, 1'b0);
        wait_done("R2");
        rd(3'd3, v); check("R2", "no-crc done", {32'b0, v}, 64'h200);
        clear_status();

        // R3 opposite edges
        drive_pos_b = 1'b0;
        latch_neg_b = 1'b1;
        wr(3'd2, 32'h0006_7000);
        issue(6'd7, 32'h0f0f_a5a5, 32'h0000_2d00, 1'b1);
        card_rsp(short_rsp(6'd7, 32'h8000_0001, 1'b0), 48);
        wait_done("R3");
        rd(3'd3, v); check("R3", "edge swap", {32'b0, v}, 64'h220);
        clear_status();
        drive_pos_b = 1'b1;
        latch_neg_b = 1'b0;
        wr(3'd2, 32'h0002_7800);

        // R10 interrupt disabled
        wr(3'd4, 32'h0);
        issue(6'd0, 32'h0, 32'h0, 1'b1);
        wait_done("R10");
        @(negedge clk); check("R10", "irq masked", {63'b0, irq}, 64'd0);
        clear_status();

        // R12 soft reset while waiting for a response
        issue(6'd9, 32'h0, 32'h0000_2d00, 1'b1);
        wait (cmd_oe);
        wait (!cmd_oe);
        repeat (5) @(posedge clk);
        wr(3'd4, 32'h8010);
        rd(3'd3, v); check("R12", "status after abort", {32'b0, v}, 64'h0);
        check("R12", "line released", {63'b0, cmd_oe}, 64'd0);
        repeat (200) @(posedge clk);
        rd(3'd3, v); check("R12", "no late done", {32'b0, v}, 64'h0);
        issue(6'd0, 32'h0, 32'h0, 1'b1);
        wait_done("R12");
        repeat (20) @(posedge clk);
        check("R2", "frames all seen", 64'(exp_frame_q.size()), 64'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule